// File: doc/BRIEF.md
# 4B/5B Transmit Coder with Error-Injection Test Mode

This block is the transmit coding stage of a 100 Mb/s Ethernet physical layer. Every clock it takes one transmit nibble, together with a frame enable and an error strobe. It returns one registered 5-bit code group. The nibble stream has no back-pressure: the coder accepts one nibble per cycle and produces one code group per cycle. The enable marks where a frame starts and ends, and the output is the same pace as the input.

In normal operation the coder builds the frame around the data. The first two enabled cycles become the start pair J, K. The data nibbles use the standard data table. The end of the frame is marked by T, R, and the line carries idle between frames. A test input gives the error strobe a second job. While the test input is high, an asserted strobe selects a fixed alternate table, which can emit invalid or misplaced control code groups, so that downstream decoders can be exercised. A stream cipher then XORs an 11-bit LFSR key onto the code group. The cipher runs only when it is enabled and the link is in 100 Mb/s mode.

Top module: `tx_coder_4b5b`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `code_out` is 11111. The cipher register is loaded with `SCR_SEED`, and the framing logic is idle.
- R2: With `err_test_mode` low, each data nibble inside a frame maps as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R3: When `tx_en` is seen high while idle, the code group J (11000) is sent in place of that nibble. The next cycle always carries K (10001), even if `tx_en` has already dropped.
- R4: When `tx_en` drops, T (01101) is sent in that cycle, and R (00111) follows in the next cycle. A frame of one enabled cycle yields J, K, T, R. A high `tx_en` during the R cycle does not start a frame; the start is taken in the cycle after it.
- R5: Outside a frame and its T/R tail, the coder sends idle 11111.
- R6: With `err_test_mode` low, `tx_er` high on a data cycle sends H (00100) instead of the data code. `tx_er` has no effect on idle, J, K, T or R.
- R7: With `err_test_mode` high and `tx_er` high, the output is taken from the test table in any framing state. Nibbles 0–7 map to 0 followed by the nibble (00000–00111). The rest map as 8→00000, 9→01101, A→01100, B→10001, C→10000, D→11001, E→11000, F→11111. The framing state still advances as it would in normal mode.
- R8: With `err_test_mode` high and `tx_er` low, the output is identical to normal mode.
- R9: When the cipher is active, each code group is XORed with 5 key bits. One LFSR step computes f = s[10] xor s[8] (polynomial x^11+x^9+1) and then shifts s left with f entering bit 0. The first step's f covers code bit 4, and the fifth step's f covers bit 0. The LFSR takes 5 steps every clock, whether the cipher is active or not.
- R10: With `cipher_off` high, code groups leave unscrambled, idles included.
- R11: With `link_100` low, the cipher is bypassed whatever `cipher_off` holds.
- R12: The code group for the inputs sampled at one rising edge appears on `code_out` right after that edge, which is one cycle of latency. The control inputs are sampled at the same edge as the nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one code group per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable for the nibble stream |
| tx_er | input | 1 | Transmit error strobe |
| txd | input | 4 | Transmit nibble |
| err_test_mode | input | 1 | Lets `tx_er` select the test table |
| cipher_off | input | 1 | Bypasses the stream cipher when high |
| link_100 | input | 1 | High in 100 Mb/s mode; low forces cipher bypass |
| code_out | output | 5 | Registered 5-bit code group |

## Verification
One frame carries all sixteen nibble values with the cipher off. This shows that the data table is correct and that exactly the first two nibbles are replaced by the start pair. Frames of one and two cycles, and an enable that rises during the R slot, separate the forced K and tail rules from a naive edge detector. The error strobe is driven inside frames, between frames and during the start pair, in both modes, covering all sixteen nibbles in the test table. This tells H substitution apart from test-table override, and shows that the framing keeps advancing underneath an override. Last, frames and idles are sent with the cipher on, then with each bypass input toggled. This checks the key sequence bit by bit, and confirms that the LFSR keeps running while bypassed.

// File: rtl/tx_coder_pkg.sv
package tx_coder_pkg;

  localparam int NIB_W = 4;
  localparam int CG_W  = 5;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;
  localparam logic [CG_W-1:0] CG_H    = 5'b00100;

  typedef enum logic [2:0] {
    SYM_I, SYM_J, SYM_K, SYM_DATA, SYM_H, SYM_T, SYM_R
  } sym_kind_e;

  typedef enum logic [2:0] {
    FR_IDLE, FR_SSD2, FR_BODY, FR_TAIL_T, FR_TAIL_R
  } fr_state_e;

  function automatic logic [CG_W-1:0] data_cg(input logic [NIB_W-1:0] nib);
    logic [CG_W-1:0] cg;
    case (nib)
      4'h0: cg = 5'b11110;
      4'h1: cg = 5'b01001;
      4'h2: cg = 5'b10100;
      4'h3: cg = 5'b10101;
      4'h4: cg = 5'b01010;
      4'h5: cg = 5'b01011;
      4'h6: cg = 5'b01110;
      4'h7: cg = 5'b01111;
      4'h8: cg = 5'b10010;
      4'h9: cg = 5'b10011;
      4'hA: cg = 5'b10110;
      4'hB: cg = 5'b10111;
      4'hC: cg = 5'b11010;
      4'hD: cg = 5'b11011;
      4'hE: cg = 5'b11100;
      default: cg = 5'b11101;
    endcase
    return cg;
  endfunction

  function automatic logic [CG_W-1:0] test_cg(input logic [NIB_W-1:0] nib);
    logic [CG_W-1:0] cg;
    if (!nib[NIB_W-1]) begin
      cg = {1'b0, nib};
    end else begin
      case (nib[NIB_W-2:0])
        3'd0: cg = 5'b00000;
        3'd1: cg = CG_T;
        3'd2: cg = 5'b01100;
        3'd3: cg = CG_K;
        3'd4: cg = 5'b10000;
        3'd5: cg = 5'b11001;
        3'd6: cg = CG_J;
        default: cg = CG_IDLE;
      endcase
    end
    return cg;
  endfunction

endpackage

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
  import tx_coder_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_en,
  input  logic      tx_er,
  output sym_kind_e sym_o
);

  fr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    sym_o   = SYM_I;
    case (state_q)
      FR_IDLE: begin
        if (tx_en) begin
          sym_o   = SYM_J;
          state_d = FR_SSD2;
        end
      end
      FR_SSD2: begin
        sym_o   = SYM_K;
        state_d = tx_en ? FR_BODY : FR_TAIL_T;
      end
      FR_BODY: begin
        if (tx_en) begin
          sym_o = tx_er ? SYM_H : SYM_DATA;
        end else begin
          sym_o   = SYM_T;
          state_d = FR_TAIL_R;
        end
      end
      FR_TAIL_T: begin
        sym_o   = SYM_T;
        state_d = FR_TAIL_R;
      end
      FR_TAIL_R: begin
        sym_o   = SYM_R;
        state_d = FR_IDLE;
      end
      default: begin
        sym_o   = SYM_I;
        state_d = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FR_IDLE;
    else        state_q <= state_d;
  end

  assert_k_after_j_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_o == SYM_J |=> sym_o == SYM_K);

  assert_r_after_t_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_o == SYM_T |=> sym_o == SYM_R);

  assert_no_start_in_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_o == SYM_R |=> (sym_o == SYM_I || sym_o == SYM_J));

  assert_idle_only_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_o == SYM_I |-> !tx_en);

  assert_h_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sym_o == SYM_H |-> (tx_en && tx_er && $past(tx_en)));

endmodule

// File: rtl/tx_cg_mapper.sv
module tx_cg_mapper
  import tx_coder_pkg::*;
(
  input  sym_kind_e        sym_i,
  input  logic [NIB_W-1:0] txd,
  input  logic             tx_er,
  input  logic             err_test_mode,
  output logic [CG_W-1:0]  cg_o
);

  logic [CG_W-1:0] frame_cg;
  logic            use_test;

  always_comb begin
    case (sym_i)
      SYM_J:    frame_cg = CG_J;
      SYM_K:    frame_cg = CG_K;
      SYM_DATA: frame_cg = data_cg(txd);
      SYM_H:    frame_cg = CG_H;
      SYM_T:    frame_cg = CG_T;
      SYM_R:    frame_cg = CG_R;
      default:  frame_cg = CG_IDLE;
    endcase
  end

  assign use_test = err_test_mode && tx_er;
  assign cg_o     = use_test ? test_cg(txd) : frame_cg;

endmodule

// File: rtl/tx_cipher_lfsr.sv
module tx_cipher_lfsr #(
  parameter int            LFSR_W  = 11,
  parameter int            TAP_HI  = 10,
  parameter int            TAP_LO  = 8,
  parameter int            STEPS   = 5,
  parameter logic [LFSR_W-1:0] SEED = 11'h5A5
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [STEPS-1:0] key_o
);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] chain [STEPS+1];
  logic [STEPS-1:0]  fb;

  assign chain[0] = state_q;

  for (genvar gi = 0; gi < STEPS; gi++) begin : g_step
    assign fb[gi]             = chain[gi][TAP_HI] ^ chain[gi][TAP_LO];
    assign key_o[STEPS-1-gi]  = fb[gi];
    assign chain[gi+1]        = {chain[gi][LFSR_W-2:0], fb[gi]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= chain[STEPS];
  end

  assert_lfsr_alive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  assert_lfsr_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> state_q != $past(state_q));

endmodule

// File: rtl/tx_coder_4b5b.sv
module tx_coder_4b5b
  import tx_coder_pkg::*;
#(
  parameter int                LFSR_W   = 11,
  parameter int                TAP_HI   = 10,
  parameter int                TAP_LO   = 8,
  parameter logic [LFSR_W-1:0] SCR_SEED = 11'h5A5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [3:0]       txd,
  input  logic             err_test_mode,
  input  logic             cipher_off,
  input  logic             link_100,
  output logic [4:0]       code_out
);

  sym_kind_e       sym;
  logic [CG_W-1:0] raw_cg;
  logic [CG_W-1:0] key;
  logic            scr_on;
  logic [CG_W-1:0] cg_q;

  tx_frame_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_en (tx_en),
    .tx_er (tx_er),
    .sym_o (sym)
  );

  tx_cg_mapper u_map (
    .sym_i         (sym),
    .txd           (txd),
    .tx_er         (tx_er),
    .err_test_mode (err_test_mode),
    .cg_o          (raw_cg)
  );

  tx_cipher_lfsr #(
    .LFSR_W (LFSR_W),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO),
    .STEPS  (CG_W),
    .SEED   (SCR_SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .key_o (key)
  );

  assign scr_on = link_100 && !cipher_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cg_q <= CG_IDLE;
    else        cg_q <= raw_cg ^ (scr_on ? key : '0);
  end

  assign code_out = cg_q;

  assert_bypass_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cipher_off && sym == SYM_I && !(err_test_mode && tx_er)) |=> code_out == CG_IDLE);

  assert_slow_link_plain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_100 && sym == SYM_J && !(err_test_mode && tx_er)) |=> code_out == CG_J);

  assert_test_f_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_test_mode && tx_er && txd == 4'hF && !scr_on) |=> code_out == 5'b11111);

  assert_h_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scr_on && sym == SYM_H && !err_test_mode) |=> code_out == CG_H);

endmodule

// File: tb/tx_coder_4b5b_tb.sv
module tx_coder_4b5b_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [10:0] SEED = 11'h5A5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       err_test_mode = 1'b0;
  logic       cipher_off = 1'b1;
  logic       link_100 = 1'b1;
  logic [4:0] code_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  tx_coder_4b5b #(.SCR_SEED(SEED)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_en         (tx_en),
    .tx_er         (tx_er),
    .txd           (txd),
    .err_test_mode (err_test_mode),
    .cipher_off    (cipher_off),
    .link_100      (link_100),
    .code_out      (code_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference tables written from R2 and R7
  logic [4:0] ref_data [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                5'b11010, 5'b11011, 5'b11100, 5'b11101};
  logic [4:0] ref_test [16] = '{5'b00000, 5'b00001, 5'b00010, 5'b00011,
                                5'b00100, 5'b00101, 5'b00110, 5'b00111,
                                5'b00000, 5'b01101, 5'b01100, 5'b10001,
                                5'b10000, 5'b11001, 5'b11000, 5'b11111};

  // Behavioural model: phase of the frame as a small integer
  int         m_phase;
  logic [10:0] m_lfsr;
  logic [4:0]  exp_code = 5'b11111;

  function automatic logic [15:0] key_step(input logic [10:0] s);
    logic [4:0] k;
    logic       f;
    for (int i = 0; i < 5; i++) begin
      f = s[10] ^ s[8];
      k[4-i] = f;
      s = {s[9:0], f};
    end
    return {k, s};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [4:0]  c;
    logic [15:0] ks;
    int          np;
    if (!rst_n) begin
      m_phase  <= 0;
      m_lfsr   <= SEED;
      exp_code <= 5'b11111;
    end else begin
      c = 5'b11111;
      np = m_phase;
      case (m_phase)
        0: if (tx_en) begin c = 5'b11000; np = 1; end
        1: begin c = 5'b10001; np = tx_en ? 2 : 3; end
        2: if (tx_en) c = tx_er ? 5'b00100 : ref_data[txd];
           else begin c = 5'b01101; np = 4; end
        3: begin c = 5'b01101; np = 4; end
        default: begin c = 5'b00111; np = 0; end
      endcase
      if (err_test_mode && tx_er) c = ref_test[txd];
      ks = key_step(m_lfsr);
      if (!cipher_off && link_100) c = c ^ ks[15:11];
      m_phase  <= np;
      m_lfsr   <= ks[10:0];
      exp_code <= c;
    end
  end

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: code_out actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // R12: every cycle compares the registered output one edge after its inputs
  always @(negedge clk) begin
    if (rst_n && !done) chk(cur_req, code_out, exp_code);
  end

  task automatic drive(input logic en, input logic er, input logic [3:0] d);
    @(negedge clk);
    tx_en = en;
    tx_er = er;
    txd   = d;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 4'h0);
  endtask

  task automatic frame(input int len, input logic [3:0] first, input int er_at);
    for (int i = 0; i < len; i++) drive(1'b1, (i == er_at), first + 4'(i));
    drive(1'b0, 1'b0, 4'h0);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    // R1: reset value
    repeat (3) @(negedge clk);
    chk("R1", code_out, 5'b11111);
    rst_n = 1'b1;
    cur_req = "R1";
    idle_cycles(3);

    // R2 R3 R4 R12: full data table in one frame, cipher bypassed
    cur_req = "R2/R3/R4/R12";
    frame(18, 4'hE, -1);
    idle_cycles(3);

    // R3 R4: short frames and a start requested during the R slot
    cur_req = "R3/R4";
    frame(1, 4'h5, -1);
    idle_cycles(2);
    frame(2, 4'h5, -1);
    idle_cycles(2);
    frame(4, 4'h1, -1);
    drive(1'b1, 1'b0, 4'h9);
    frame(3, 4'h3, -1);
    idle_cycles(3);

    // R5 R6: strobe in data, on start pair, while idle, test mode off
    cur_req = "R5/R6";
    frame(8, 4'h2, 5);
    frame(6, 4'h7, 0);
    frame(6, 4'h7, 1);
    for (int n = 0; n < 16; n++) drive(1'b0, 1'b1, 4'(n));
    idle_cycles(2);

    // R7: test table in idle and inside a frame
    cur_req = "R7";
    err_test_mode = 1'b1;
    for (int n = 0; n < 16; n++) drive(1'b0, 1'b1, 4'(n));
    idle_cycles(1);
    for (int n = 0; n < 16; n++) drive(1'b1, 1'b1, 4'(n));
    drive(1'b0, 1'b1, 4'h7);
    drive(1'b0, 1'b1, 4'hB);
    idle_cycles(2);

    // R8: test mode with strobe low equals normal mode
    cur_req = "R8";
    frame(10, 4'h6, -1);
    idle_cycles(2);
    err_test_mode = 1'b0;

    // R9: cipher active on frames and idles
    cur_req = "R9";
    cipher_off = 1'b0;
    idle_cycles(5);
    frame(20, 4'h0, 7);
    idle_cycles(6);

    // R10: cipher disabled while the key keeps running
    cur_req = "R10";
    cipher_off = 1'b1;
    idle_cycles(4);
    frame(5, 4'hA, -1);
    idle_cycles(2);
    cipher_off = 1'b0;
    cur_req = "R9/R10";
    idle_cycles(4);

    // R11: slow link forces bypass whatever cipher_off holds
    cur_req = "R11";
    link_100 = 1'b0;
    idle_cycles(3);
    frame(6, 4'h4, 2);
    idle_cycles(3);
    link_100 = 1'b1;
    cur_req = "R9/R11";
    frame(4, 4'hC, -1);
    idle_cycles(3);

    // R7 R9: test override under the cipher
    cur_req = "R7/R9";
    err_test_mode = 1'b1;
    for (int n = 0; n < 16; n++) drive(1'b0, 1'b1, 4'(n));
    idle_cycles(2);

    finish_run();
  end

endmodule